// File: doc/BRIEF.md
# Negative-Pulse Threshold Discriminator

This block watches signed samples from a pulse digitizer and converts each qualifying negative-going excursion into a clean logic pulse of programmed length. A pulse qualifies when it drops below a supplied baseline by more than a programmed threshold. Each sample is measured as its depth below the baseline, `baseline - sample`. A qualifying sample starts a fixed-length output pulse, and a hit counter records every pulse issued.

Detection is edge-based and non-retriggering. After a crossing, the block stays disarmed until a valid sample falls back to or under the threshold. Crossings that arrive while a pulse is running are dropped, and so are crossings that arrive while the common veto is high. A veto that rises during a pulse leaves that pulse at its full length. The baseline, threshold and width are held in registers that the surrounding logic supplies.

Top module: `thresh_disc`

## Requirements
- R1: While reset is high and in the first cycle after it, `pulse_out` is 0 and `hit_count` is 0.
- R2: A valid sample qualifies only when its depth, `baseline - sample` computed in two's complement one bit wider than the sample, is strictly greater than `threshold` (unsigned). A depth equal to the threshold does not qualify. A sample above the baseline never qualifies.
- R3: A qualifying crossing taken at clock edge k drives `pulse_out` high from edge k onward. It stays high for exactly `out_width` cycles.
- R4: An `out_width` of 0 gives a pulse one cycle long.
- R5: Consecutive valid samples that stay above threshold produce exactly one pulse. The block re-arms only on a valid sample whose depth is not above threshold.
- R6: A crossing taken while `pulse_out` is high is ignored. It neither lengthens nor restarts the pulse, and it consumes the arming, so a later pulse needs a fresh return below threshold.
- R7: A crossing taken while `veto` is high produces no pulse and also consumes the arming.
- R8: Raising `veto` while a pulse is running does not shorten that pulse.
- R9: Samples with `sample_valid` low neither fire nor re-arm.
- R10: `hit_count` increments by one at the same edge at which `pulse_out` rises, and changes at no other time except on clear.
- R11: `hit_count` saturates at 65535.
- R12: `cnt_clear` zeroes `hit_count` at the next edge, and it wins over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies `sample` |
| sample | input | 12 | Signed digitizer sample |
| baseline | input | 12 | Signed baseline level |
| threshold | input | 12 | Unsigned depth threshold |
| out_width | input | 8 | Output pulse length in cycles (0 means 1) |
| veto | input | 1 | Common inhibit for new pulses |
| cnt_clear | input | 1 | Synchronous hit counter clear |
| pulse_out | output | 1 | Standard logic output pulse |
| hit_count | output | 16 | Saturating count of emitted pulses |

## Verification
The sample taken at a clock edge decides `pulse_out` and `hit_count` right after that same edge, with no extra pipeline stage. The bench therefore drives each sample at a falling edge and reads both outputs at the next falling edge. Pulse length is measured by counting the falling edges at which `pulse_out` reads high, starting at the edge that follows the crossing. A clear is checked one edge after it is applied, and saturation is checked after enough crossing and re-arm pairs have been driven to pass 65535.

// File: rtl/disc_pkg.sv
package disc_pkg;
    parameter int SAMPLE_W = 12;
    parameter int WIDTH_W  = 8;
    parameter int COUNT_W  = 16;

    localparam int DEPTH_W = SAMPLE_W + 1;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [DEPTH_W-1:0]  depth_t;
    typedef logic        [SAMPLE_W-1:0] thresh_t;
    typedef logic        [WIDTH_W-1:0]  width_t;
    typedef logic        [COUNT_W-1:0]  count_t;

    localparam count_t COUNT_MAX = '1;

    typedef enum logic {
        ARM_OFF = 1'b0,
        ARM_ON  = 1'b1
    } arm_e;

    typedef struct packed {
        logic valid;
        logic above;
    } level_t;

    function automatic depth_t depth_below(input sample_t base, input sample_t smp);
        depth_t b, s;
        b = depth_t'(base);
        s = depth_t'(smp);
        return b - s;
    endfunction

    function automatic width_t eff_width(input width_t w);
        return (w == '0) ? width_t'(1) : w;
    endfunction
endpackage

// File: rtl/disc_compare.sv
module disc_compare
    import disc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sample_valid,
    input  sample_t sample,
    input  sample_t baseline,
    input  thresh_t threshold,
    input  logic    veto,
    input  logic    busy,
    output logic    fire
);
    level_t lvl;
    arm_e   arm_q;
    depth_t depth;

    always_comb begin
        depth     = depth_below(baseline, sample);
        lvl.valid = sample_valid;
        lvl.above = depth > $signed({1'b0, threshold});
    end

    assign fire = lvl.valid && lvl.above && (arm_q == ARM_ON) && !veto && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            arm_q <= ARM_ON;
        else if (lvl.valid)
            arm_q <= lvl.above ? ARM_OFF : ARM_ON;
    end

    AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        fire |=> arm_q == ARM_OFF) else $error("fire left block armed"); // R5
endmodule

// File: rtl/disc_stretch.sv
module disc_stretch
    import disc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  width_t width,
    output logic   active
);
    width_t remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (fire)
            remain_q <= eff_width(width);
        else if (remain_q != '0)
            remain_q <= remain_q - width_t'(1);
    end

    assign active = (remain_q != '0);

    AST_ACTIVE_AFTER_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> active) else $error("fire did not start pulse"); // R3
endmodule

// File: rtl/disc_counter.sv
module disc_counter
    import disc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   inc,
    output count_t count
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (inc && count != COUNT_MAX)
            count <= count + count_t'(1);
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == '0) else $error("clear ignored"); // R12
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (count == COUNT_MAX && !clear) |=> count == COUNT_MAX) else $error("wrap"); // R11
endmodule

// File: rtl/thresh_disc.sv
module thresh_disc
    import disc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] baseline,
    input  logic [SAMPLE_W-1:0] threshold,
    input  logic [WIDTH_W-1:0]  out_width,
    input  logic                veto,
    input  logic                cnt_clear,
    output logic                pulse_out,
    output logic [COUNT_W-1:0]  hit_count
);
    logic fire;
    logic active;

    disc_compare u_cmp (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample       (sample_t'(sample)),
        .baseline     (sample_t'(baseline)),
        .threshold    (thresh_t'(threshold)),
        .veto         (veto),
        .busy         (active),
        .fire         (fire)
    );

    disc_stretch u_str (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .width  (width_t'(out_width)),
        .active (active)
    );

    disc_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (fire),
        .count (hit_count)
    );

    assign pulse_out = active;

    AST_VETO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> !$past(veto)) else $error("pulse under veto"); // R7
    AST_RISE_FROM_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> $past(sample_valid)) else $error("pulse without sample"); // R9
    AST_COUNT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ($rose(pulse_out) && !$past(cnt_clear) && $past(hit_count) != COUNT_MAX)
        |-> hit_count == $past(hit_count) + 16'd1) else $error("count step"); // R10
    AST_COUNT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!$rose(pulse_out) && !$past(cnt_clear)) |-> $stable(hit_count)) else $error("stray count"); // R10
endmodule

// File: tb/thresh_disc_tb_top.sv
module thresh_disc_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [11:0] sample;
    logic [11:0] baseline;
    logic [11:0] threshold;
    logic [7:0]  out_width;
    logic        veto;
    logic        cnt_clear;
    logic        pulse_out;
    logic [15:0] hit_count;

    int checks = 0;
    int fails  = 0;
    int rises  = 0;
    int highs  = 0;
    logic prev_pulse = 1'b0;
    bit done = 1'b0;

    localparam logic [11:0] BASE  = 12'd100;
    localparam logic [11:0] THR   = 12'd50;
    localparam logic [11:0] DEEP  = 12'd40;   // depth 60
    localparam logic [11:0] QUIET = 12'd100;  // depth 0

    always #5 clk = ~clk;

    thresh_disc dut_i (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample(sample),
        .baseline(baseline), .threshold(threshold), .out_width(out_width),
        .veto(veto), .cnt_clear(cnt_clear), .pulse_out(pulse_out), .hit_count(hit_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one sample at a falling edge; outputs are read at the next falling edge.
    task automatic step(input logic v, input logic [11:0] s);
        sample_valid = v;
        sample       = s;
        @(negedge clk);
        if (pulse_out) highs++;
        if (pulse_out && !prev_pulse) rises++;
        prev_pulse = pulse_out;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, QUIET);
    endtask

    task automatic zero_stats();
        rises = 0;
        highs = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        sample_valid = 1'b0; sample = QUIET; baseline = BASE; threshold = THR;
        out_width = 8'd1; veto = 1'b0; cnt_clear = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 pulse in reset", int'(pulse_out), 0);
        check("R1 count in reset", int'(hit_count), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pulse after reset", int'(pulse_out), 0);
        check("R1 count after reset", int'(hit_count), 0);
    endtask

    task automatic t_threshold();
        out_width = 8'd1;
        zero_stats();
        step(1'b1, 12'd50);            // depth 50 == threshold
        step(1'b1, QUIET);
        step(1'b1, 12'd1000);          // above baseline
        step(1'b1, QUIET);
        check("R2 equal or positive no pulse", rises, 0);
        step(1'b1, 12'd49);            // depth 51
        check("R2 depth 51 fires", int'(pulse_out), 1);
        step(1'b1, QUIET);
        step(1'b1, 12'hF00);           // -256, depth 356
        check("R2 negative sample fires", int'(pulse_out), 1);
        step(1'b1, QUIET);
        idle(2);
    endtask

    task automatic t_width();
        out_width = 8'd5;
        zero_stats();
        step(1'b1, DEEP);
        check("R3 pulse high right after crossing", int'(pulse_out), 1);
        step(1'b1, QUIET);
        idle(10);
        check("R3 width 5", highs, 5);
        out_width = 8'd0;
        zero_stats();
        step(1'b1, DEEP);
        step(1'b1, QUIET);
        idle(4);
        check("R4 width 0 gives 1", highs, 1);
    endtask

    task automatic t_long();
        out_width = 8'd2;
        zero_stats();
        for (int i = 0; i < 10; i++) step(1'b1, DEEP);
        check("R5 long pulse single output", rises, 1);
        step(1'b1, QUIET);
        step(1'b1, DEEP);
        step(1'b1, QUIET);
        idle(3);
        check("R5 rearm after return", rises, 2);
    endtask

    task automatic t_retrig();
        logic [15:0] c0;
        out_width = 8'd8;
        c0 = hit_count;
        zero_stats();
        step(1'b1, DEEP);
        step(1'b1, QUIET);
        step(1'b1, DEEP);              // crossing while active
        for (int i = 0; i < 10; i++) step(1'b1, DEEP);
        check("R6 width unchanged", highs, 8);
        check("R6 one rise", rises, 1);
        check("R6 count once", int'(hit_count - c0), 1);
        step(1'b1, QUIET);
        idle(2);
    endtask

    task automatic t_veto();
        out_width = 8'd2;
        zero_stats();
        veto = 1'b1;
        step(1'b1, DEEP);
        veto = 1'b0;
        step(1'b1, DEEP);
        step(1'b1, DEEP);
        check("R7 vetoed crossing lost", rises, 0);
        step(1'b1, QUIET);
        step(1'b1, DEEP);
        check("R7 pulse after rearm", rises, 1);
        step(1'b1, QUIET);
        idle(3);
    endtask

    task automatic t_veto_mid();
        out_width = 8'd6;
        zero_stats();
        step(1'b1, DEEP);
        veto = 1'b1;
        step(1'b1, QUIET);
        idle(9);
        veto = 1'b0;
        check("R8 veto mid pulse keeps width", highs, 6);
    endtask

    task automatic t_invalid();
        out_width = 8'd1;
        zero_stats();
        step(1'b0, DEEP);
        step(1'b0, DEEP);
        check("R9 invalid deep ignored", rises, 0);
        step(1'b1, DEEP);              // fires
        step(1'b0, QUIET);             // invalid, must not rearm
        step(1'b1, DEEP);
        step(1'b1, QUIET);
        idle(2);
        check("R9 invalid quiet does not rearm", rises, 1);
    endtask

    task automatic t_count();
        logic [15:0] c0;
        out_width = 8'd3;
        c0 = hit_count;
        step(1'b1, DEEP);
        check("R10 count with rise", int'(hit_count - c0), 1);
        step(1'b1, QUIET);
        idle(4);
        check("R10 count steady", int'(hit_count - c0), 1);
    endtask

    task automatic t_clear();
        out_width = 8'd1;
        cnt_clear = 1'b1;
        step(1'b1, DEEP);              // fire and clear together
        cnt_clear = 1'b0;
        check("R12 clear beats increment", int'(hit_count), 0);
        check("R12 pulse still issued", int'(pulse_out), 1);
        step(1'b1, QUIET);
        idle(1);
    endtask

    task automatic t_sat();
        out_width = 8'd1;
        cnt_clear = 1'b1;
        step(1'b0, QUIET);
        cnt_clear = 1'b0;
        for (int i = 0; i < 65540; i++) begin
            step(1'b1, DEEP);
            step(1'b1, QUIET);
        end
        check("R11 saturates", int'(hit_count), 65535);
        cnt_clear = 1'b1;
        step(1'b0, QUIET);
        cnt_clear = 1'b0;
        check("R12 clear from max", int'(hit_count), 0);
    endtask

    initial begin
        t_reset();
        t_threshold();
        t_width();
        t_long();
        t_retrig();
        t_veto();
        t_veto_mid();
        t_invalid();
        t_count();
        t_clear();
        t_sat();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule